// File: doc/BRIEF.md
# Soft-Decision Butterfly Add-Compare-Select Engine

This block performs the path-metric update of a 16-state Viterbi decoder for a rate-1/2 convolutional code with constraint length 5. In each symbol interval it takes two signed soft-decision samples. It turns them into two branch metrics, their sum and their difference. It then runs eight add-compare-select butterflies over the previous interval's path metrics. The metrics are correlation scores, so the larger accumulated value survives.

Path metrics are held in two register banks. One bank is read and the other is written, and the two exchange roles after every accepted symbol. The sixteen survivor decisions of an interval are packed into one 16-bit transition word. A traceback unit downstream stores these words and walks back through them to recover the decoded bits.

A frame-start pulse loads the starting metrics: zero for state 0, and the most negative value for every other state. Accumulation saturates at the signed limits. A common offset is taken off all metrics whenever state 0's new metric passes a threshold, which keeps the metrics away from the top limit.

Top module: `acs_engine`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows trn_valid = 0 and trn_word = 16'h0000, and the path metrics are loaded with the frame-start values of R7.
- R2: Each soft sample is 3-bit sign-magnitude. Bit 2 is the sign (1 = negative) and bits 1:0 are the magnitude, so 3'b000 and 3'b100 both mean zero. The branch metrics are sum = s0 + s1 and diff = s0 − s1, each sign-extended to 16 bits.
- R3: Butterfly J with J even is direct. It gives new(J) = max(old(2J)+m, old(2J+1)−m) and new(J+8) = max(old(2J)−m, old(2J+1)+m).
- R4: Butterfly J with J odd is reverse. It gives new(J) = max(old(2J)−m, old(2J+1)+m) and new(J+8) = max(old(2J)+m, old(2J+1)−m). Butterflies 0 to 3 use m = sum and butterflies 4 to 7 use m = diff.
- R5: Each selection keeps the larger candidate. Its decision bit is 1 when the path from 2J+1 is strictly larger and 0 otherwise, so a tie keeps the path from 2J.
- R6: trn_word bit 15−2J holds the decision for new state J, and bit 14−2J holds the decision for new state J+8. From MSB to LSB the order is therefore 0,8,1,9,…,7,15.
- R7: frame_start loads state 0 with 0 and all other states with 16'h8000. If sym_valid is high in the same cycle, that symbol is processed from these starting metrics.
- R8: Each accepted symbol reads the metrics written by the previous accepted symbol, so the banks swap after every interval. frame_start alone produces no output.
- R9: Every add and subtract saturates to the range [−32768, 32767]. For example, 16'h8000 − 6 stays at 16'h8000.
- R10: When state 0's new metric is greater than NORM_THRESH, NORM_OFFSET is subtracted, with saturation, from all 16 new metrics before they are stored.
- R11: trn_valid is high for exactly the cycle after each cycle with sym_valid high, and trn_word changes only on those updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Load starting path metrics |
| sym_valid | input | 1 | Soft pair is present this cycle |
| sd0 | input | 3 | First soft sample, sign-magnitude |
| sd1 | input | 3 | Second soft sample, sign-magnitude |
| trn_valid | output | 1 | trn_word is fresh this cycle |
| trn_word | output | 16 | Packed survivor decisions of the last interval |

## Verification
The first interval after a frame start compares metrics stuck at 16'h8000 against each other. A design that wraps instead of saturating turns 16'h8000 − 6 into a large positive value and flips several decision bits. A design that resolves ties toward the lower path sets bits that should stay zero, and a zero-valued soft pair exposes that. A long run of strong, mostly consistent samples drives state 0 past the normalization threshold. Without the offset step the metrics climb into the top saturation limit and the decisions collapse into ties. Random streams with idle gaps and frame starts in mid-stream expose bank-swap, bit-ordering and direct/reverse mix-ups as wrong transition words.

// File: rtl/acs_pkg.sv
// Package: shared types of the add-compare-select engine.
// Assumes: nothing beyond IEEE 1800-2017.
package acs_pkg;

    // Sign pattern of one butterfly
    typedef enum logic {
        BFLY_DIRECT  = 1'b0,
        BFLY_REVERSE = 1'b1
    } bfly_kind_e;

endpackage

// File: rtl/acs_branch_metric.sv
// Module: converts two sign-magnitude soft samples into the sum and
// difference branch metrics.
// Assumes: SOFT_W >= 2 with the MSB as sign, and MW wide enough that the
// sum of two samples cannot overflow.
module acs_branch_metric #(
    parameter int SOFT_W = 3,
    parameter int MW     = 16
) (
    input  logic [SOFT_W-1:0]    sd0,
    input  logic [SOFT_W-1:0]    sd1,
    output logic signed [MW-1:0] bm_sum,
    output logic signed [MW-1:0] bm_diff
);

    localparam int PAD = MW - SOFT_W + 1;

    logic signed [MW-1:0] mag0, mag1, val0, val1;

    // Sign-magnitude to two's complement, then sum and difference
    always_comb begin
        mag0    = {{PAD{1'b0}}, sd0[SOFT_W-2:0]};
        mag1    = {{PAD{1'b0}}, sd1[SOFT_W-2:0]};
        val0    = sd0[SOFT_W-1] ? -mag0 : mag0;
        val1    = sd1[SOFT_W-1] ? -mag1 : mag1;
        bm_sum  = val0 + val1;
        bm_diff = val0 - val1;
    end

endmodule

// File: rtl/acs_butterfly.sv
// Module: one add-compare-select butterfly with saturating adds.
// Inputs are the old metrics of states 2J (up) and 2J+1 (lo) and the
// branch metric m. KIND picks the direct or reverse sign pattern.
// A decision is 1 only when the lo path is strictly larger.
// Assumes: m is never the most negative value, so -m is exact.
module acs_butterfly
    import acs_pkg::*;
#(
    parameter int         MW   = 16,
    parameter bfly_kind_e KIND = BFLY_DIRECT
) (
    input  logic signed [MW-1:0] old_up,
    input  logic signed [MW-1:0] old_lo,
    input  logic signed [MW-1:0] m,
    output logic signed [MW-1:0] new_j,
    output logic signed [MW-1:0] new_j8,
    output logic                 dec_j,
    output logic                 dec_j8
);

    localparam logic signed [MW-1:0] SMAX = {1'b0, {(MW-1){1'b1}}};
    localparam logic signed [MW-1:0] SMIN = {1'b1, {(MW-1){1'b0}}};

    function automatic logic signed [MW-1:0] sat_add(
        input logic signed [MW-1:0] a,
        input logic signed [MW-1:0] b
    );
        logic signed [MW:0] s;
        s = {a[MW-1], a} + {b[MW-1], b};
        if (s[MW] != s[MW-1]) return s[MW] ? SMIN : SMAX;
        return s[MW-1:0];
    endfunction

    logic signed [MW-1:0] m_pos, m_neg;
    logic signed [MW-1:0] up_j, lo_j, up_j8, lo_j8;

    // Pick the signs for this butterfly type
    always_comb begin
        m_pos = (KIND == BFLY_DIRECT) ? m : -m;
        m_neg = -m_pos;
    end

    // Candidate metrics into each new state
    always_comb begin
        up_j  = sat_add(old_up, m_pos);
        lo_j  = sat_add(old_lo, m_neg);
        up_j8 = sat_add(old_up, m_neg);
        lo_j8 = sat_add(old_lo, m_pos);
    end

    // Compare and select; ties keep the up path
    always_comb begin
        dec_j  = (lo_j  > up_j);
        dec_j8 = (lo_j8 > up_j8);
        new_j  = dec_j  ? lo_j  : up_j;
        new_j8 = dec_j8 ? lo_j8 : up_j8;
    end

endmodule

// File: rtl/acs_normalizer.sv
// Module: subtracts a common offset from all new metrics when state 0's
// metric is above the threshold. The subtraction saturates at the floor.
// Assumes: 0 < OFFSET < 2**(MW-1).
module acs_normalizer #(
    parameter int MW     = 16,
    parameter int NSTATE = 16,
    parameter int THRESH = 16384,
    parameter int OFFSET = 8192
) (
    input  logic signed [MW-1:0] raw_m [NSTATE],
    output logic signed [MW-1:0] out_m [NSTATE]
);

    localparam logic signed [MW-1:0] SMIN  = {1'b1, {(MW-1){1'b0}}};
    localparam logic signed [MW:0]   OFS_X = (MW+1)'(OFFSET);
    localparam logic signed [MW-1:0] THR_M = MW'(THRESH);

    logic             shift_en;
    logic signed [MW:0] diff_x [NSTATE];

    // Trigger on state 0 only
    always_comb shift_en = (raw_m[0] > THR_M);

    // Offset every state, clamping at the negative limit
    always_comb begin
        for (int i = 0; i < NSTATE; i++) begin
            diff_x[i] = {raw_m[i][MW-1], raw_m[i]} - OFS_X;
            if (!shift_en)
                out_m[i] = raw_m[i];
            else if (diff_x[i][MW] != diff_x[i][MW-1])
                out_m[i] = SMIN;
            else
                out_m[i] = diff_x[i][MW-1:0];
        end
    end

endmodule

// File: rtl/acs_engine.sv
// Module: path-metric update engine of a 16-state Viterbi decoder
// (rate 1/2, constraint length 5). Each accepted soft pair runs eight
// butterflies from the read bank into the write bank and swaps the
// banks. The packed decisions appear on trn_word one cycle later.
// Assumes: synchronous active-low reset; frame_start takes effect before
// a symbol in the same cycle.
module acs_engine
    import acs_pkg::*;
#(
    parameter int SOFT_W      = 3,
    parameter int METRIC_W    = 16,
    parameter int CONSTR_LEN  = 5,
    parameter int NORM_THRESH = 16384,
    parameter int NORM_OFFSET = 8192
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        sym_valid,
    input  logic [SOFT_W-1:0]           sd0,
    input  logic [SOFT_W-1:0]           sd1,
    output logic                        trn_valid,
    output logic [(1<<(CONSTR_LEN-1))-1:0] trn_word
);

    localparam int NSTATE = 1 << (CONSTR_LEN - 1);
    localparam int NBFLY  = NSTATE / 2;
    localparam int MW     = METRIC_W;
    localparam logic signed [MW-1:0] M_FLOOR = {1'b1, {(MW-1){1'b0}}};

    function automatic logic signed [MW-1:0] start_metric(input int idx);
        return (idx == 0) ? '0 : M_FLOOR;
    endfunction

    logic                 bank_sel;
    logic                 rd_sel;
    logic signed [MW-1:0] bank_q [2][NSTATE];
    logic signed [MW-1:0] old_m  [NSTATE];
    logic signed [MW-1:0] raw_m  [NSTATE];
    logic signed [MW-1:0] nrm_m  [NSTATE];
    logic signed [MW-1:0] cur_state0;
    logic signed [MW-1:0] bm_sum, bm_diff;
    logic [NSTATE-1:0]    dec_word;

    // Branch metrics from the soft pair
    acs_branch_metric #(
        .SOFT_W (SOFT_W),
        .MW     (MW)
    ) bm_i (
        .sd0     (sd0),
        .sd1     (sd1),
        .bm_sum  (bm_sum),
        .bm_diff (bm_diff)
    );

    // Select the read bank, or the starting metrics on frame_start
    always_comb begin
        rd_sel = frame_start ? 1'b0 : bank_sel;
        for (int i = 0; i < NSTATE; i++)
            old_m[i] = frame_start ? start_metric(i) : bank_q[rd_sel][i];
    end

    // Eight butterflies: kind alternates, first half uses the sum
    for (genvar j = 0; j < NBFLY; j++) begin : g_bfly
        localparam bfly_kind_e KIND = (j % 2 == 0) ? BFLY_DIRECT : BFLY_REVERSE;
        logic signed [MW-1:0] m_sel;
        assign m_sel = (j < NBFLY / 2) ? bm_sum : bm_diff;

        acs_butterfly #(
            .MW   (MW),
            .KIND (KIND)
        ) bf_i (
            .old_up (old_m[2*j]),
            .old_lo (old_m[2*j+1]),
            .m      (m_sel),
            .new_j  (raw_m[j]),
            .new_j8 (raw_m[j+NBFLY]),
            .dec_j  (dec_word[NSTATE-1-2*j]),
            .dec_j8 (dec_word[NSTATE-2-2*j])
        );
    end

    // Offset correction of the new metrics
    acs_normalizer #(
        .MW     (MW),
        .NSTATE (NSTATE),
        .THRESH (NORM_THRESH),
        .OFFSET (NORM_OFFSET)
    ) norm_i (
        .raw_m (raw_m),
        .out_m (nrm_m)
    );

    // Current state-0 metric for observation
    always_comb cur_state0 = bank_q[bank_sel][0];

    // Bank storage, bank swap and transition word output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTATE; i++) begin
                bank_q[0][i] <= start_metric(i);
                bank_q[1][i] <= start_metric(i);
            end
            bank_sel  <= 1'b0;
            trn_valid <= 1'b0;
            trn_word  <= '0;
        end else begin
            trn_valid <= sym_valid;
            if (sym_valid) begin
                for (int i = 0; i < NSTATE; i++)
                    bank_q[~rd_sel][i] <= nrm_m[i];
                bank_sel <= ~rd_sel;
                trn_word <= dec_word;
            end else if (frame_start) begin
                for (int i = 0; i < NSTATE; i++)
                    bank_q[0][i] <= start_metric(i);
                bank_sel <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/acs_engine_chk.sv
// Module: assertion checker for acs_engine, attached by bind.
// Assumes: cur_state0 and raw_state0 are the stored and unstored metrics
// of state 0 inside the engine.
module acs_engine_chk #(
    parameter int MW          = 16,
    parameter int TW          = 16,
    parameter int NORM_THRESH = 16384,
    parameter int NORM_OFFSET = 8192
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_start,
    input logic                 sym_valid,
    input logic                 trn_valid,
    input logic [TW-1:0]        trn_word,
    input logic                 bank_sel,
    input logic signed [MW-1:0] cur_state0,
    input logic signed [MW-1:0] raw_state0
);

    // R11: valid follows an accepted symbol by one cycle
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> trn_valid);

    // R11: no valid without a symbol
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> !trn_valid);

    // R11: word held between updates
    a_r11_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(trn_word));

    // R8: banks swap after every symbol in a running frame
    a_r8_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !frame_start) |=> (bank_sel != $past(bank_sel)));

    // R7: frame start alone reloads state 0 with zero in bank 0
    a_r7_frame_init: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !sym_valid) |=> (!bank_sel && cur_state0 == '0));

    // R7: a symbol in the start cycle writes bank 1
    a_r7_start_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && sym_valid) |=> bank_sel);

    // R10: offset applied when state 0 passes the threshold
    a_r10_norm_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && int'(raw_state0) > NORM_THRESH)
        |=> (int'(cur_state0) == int'($past(raw_state0)) - NORM_OFFSET));

    // R10: no offset below the threshold
    a_r10_norm_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && int'(raw_state0) <= NORM_THRESH)
        |=> (cur_state0 == $past(raw_state0)));

endmodule

bind acs_engine acs_engine_chk #(
    .MW          (METRIC_W),
    .TW          (1 << (CONSTR_LEN - 1)),
    .NORM_THRESH (NORM_THRESH),
    .NORM_OFFSET (NORM_OFFSET)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .sym_valid   (sym_valid),
    .trn_valid   (trn_valid),
    .trn_word    (trn_word),
    .bank_sel    (bank_sel),
    .cur_state0  (cur_state0),
    .raw_state0  (raw_m[0])
);

// File: tb/acs_engine_tb.sv
// Bench: behavioural reference of the metric update, compared every cycle.
module acs_engine_tb_top;

    localparam int THR = 300;
    localparam int OFS = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_start;
    logic        sym_valid;
    logic [2:0]  sd0, sd1;
    logic        trn_valid;
    logic [15:0] trn_word;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 0;

    int          mdl [16];
    logic        exp_valid;
    logic [15:0] exp_word;

    always #10 clk = ~clk;   // 50 MHz

    acs_engine #(
        .NORM_THRESH (THR),
        .NORM_OFFSET (OFS)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .sym_valid   (sym_valid),
        .sd0         (sd0),
        .sd1         (sd1),
        .trn_valid   (trn_valid),
        .trn_word    (trn_word)
    );

    function automatic int clamp16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int soft_val(input logic [2:0] x);
        return x[2] ? -int'(x[1:0]) : int'(x[1:0]);
    endfunction

    task automatic model_start();
        for (int i = 0; i < 16; i++) mdl[i] = (i == 0) ? 0 : -32768;
    endtask

    // Reference for one cycle of inputs (R2..R10)
    task automatic model_cycle(input bit fs, input bit v,
                               input logic [2:0] a, input logic [2:0] b);
        int nxt [16];
        int s, d, m, c0, c1, c2, c3;
        exp_valid = v;
        if (fs) model_start();
        if (!v) return;
        s = soft_val(a) + soft_val(b);
        d = soft_val(a) - soft_val(b);
        for (int j = 0; j < 8; j++) begin
            m = (j < 4) ? s : d;
            if (j % 2 == 1) m = -m;
            c0 = clamp16(mdl[2*j] + m);
            c1 = clamp16(mdl[2*j+1] - m);
            c2 = clamp16(mdl[2*j] - m);
            c3 = clamp16(mdl[2*j+1] + m);
            exp_word[15-2*j] = (c1 > c0);
            exp_word[14-2*j] = (c3 > c2);
            nxt[j]   = (c1 > c0) ? c1 : c0;
            nxt[j+8] = (c3 > c2) ? c3 : c2;
        end
        if (nxt[0] > THR)
            for (int i = 0; i < 16; i++) nxt[i] = clamp16(nxt[i] - OFS);
        for (int i = 0; i < 16; i++) mdl[i] = nxt[i];
    endtask

    task automatic check_out(input string tag);
        n_checks++;
        if (trn_valid !== exp_valid || trn_word !== exp_word) begin
            n_fail++;
            $display("FAIL %s: valid=%b word=%h expected valid=%b word=%h",
                     tag, trn_valid, trn_word, exp_valid, exp_word);
        end
    endtask

    task automatic check_lit(input string tag, input logic [15:0] want);
        n_checks++;
        if (trn_word !== want) begin
            n_fail++;
            $display("FAIL %s: word=%h expected %h", tag, trn_word, want);
        end
    endtask

    // Drive one cycle at the falling edge, compare at the next one
    task automatic step(input bit fs, input bit v, input logic [2:0] a,
                        input logic [2:0] b, input string tag);
        frame_start = fs; sym_valid = v; sd0 = a; sd1 = b;
        model_cycle(fs, v, a, b);
        @(posedge clk);
        @(negedge clk);
        check_out(tag);
    endtask

    initial begin
        rst_n = 1'b0; frame_start = 1'b0; sym_valid = 1'b0;
        sd0 = 3'b0; sd1 = 3'b0;
        exp_valid = 1'b0; exp_word = 16'h0;
        model_start();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_out("R1 reset state");
        // R1: first symbol after reset uses starting metrics
        step(0, 1, 3'b011, 3'b001, "R1 post-reset symbol");
        step(0, 0, 3'b000, 3'b000, "R11 idle hold");
        // R7/R9: start with strong positive pair, literal word
        step(1, 1, 3'b011, 3'b011, "R7 start+symbol");
        check_lit("R9 floor saturation", 16'h2600);
        // R5/R2: negative zero gives all ties
        step(1, 1, 3'b100, 3'b000, "R2 negative zero");
        check_lit("R5 tie keeps upper", 16'h0000);
        step(1, 0, 3'b000, 3'b000, "R8 start alone no output");
        step(0, 1, 3'b110, 3'b010, "R4 difference branch");
        step(0, 1, 3'b111, 3'b101, "R3 negative pair");
        step(0, 1, 3'b001, 3'b111, "R6 word order");
        // Random streams with gaps and restarts (R3 R4 R5 R6 R8 R11)
        for (int k = 0; k < 3000; k++) begin
            bit fs = ($urandom_range(0, 199) == 0);
            bit v  = ($urandom_range(0, 4) != 0);
            step(fs, v, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                 "R8 random stream");
        end
        // R10: steady strong input pushes state 0 past the threshold
        step(1, 0, 3'b000, 3'b000, "R7 restart");
        for (int k = 0; k < 6000; k++) begin
            if (k % 7 == 3) step(0, 1, 3'b111, 3'b010, "R10 noisy sample");
            else            step(0, 1, 3'b011, 3'b011, "R10 growth");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: cycles=200000 expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

endmodule